// File: doc/BRIEF.md
# Complementary Pair Deadtime Inserter

This block turns one raw pulse-width signal per channel pair into a high-side and a low-side drive. The two drives are complementary, and the block keeps them from overlapping. When the raw signal changes level, the drive that must switch off does so at once. The drive that must switch on waits for a programmable deadtime. During that wait both drives are inactive. If the raw signal changes again before the wait ends, the wait starts over, and the wait runs for the output that now has to come on.

The deadtime is a 12-bit count of prescaled PWM ticks, held in a register that software loads. The prescaler select gives divide-by-1, 2, 4 or 8. The block turns the count into a span of bus clock cycles. At divide-by-one the span equals the count. At every other ratio the span is the ratio times the count, less one cycle. All pairs share one deadtime register and one prescaler select, but each pair runs its own timer. In the default build there are three pairs, which can be called A, B and C.

Top module: `dtins_top`

## Requirements
- R1: For every pair, `out_hi` and `out_lo` are never 1 in the same cycle.
- R2: The block samples `pwm_raw` on each clock edge and drives registered outputs. When a rising level is sampled, `out_lo` is 0 in the cycle that follows. `out_hi` becomes 1 exactly S cycles after that sampling edge, where S is the deadtime span. While `out_hi` is 1, the raw level sampled on the previous edge was 1.
- R3: The falling level mirrors R2. `out_hi` drops in the cycle after the falling level is sampled. `out_lo` becomes 1 exactly S cycles after that edge. While `out_lo` is 1, the raw level sampled on the previous edge was 0.
- R4: `presc_sel` encodes the ratio P: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. At `presc_sel`=0 the span S equals the deadtime value. At any other setting S is P×value−1, so ratio 2 with value 5 gives 9. A value of 0 gives S=0 at every ratio.
- R5: When S is 0, each output follows `pwm_raw` one cycle late: `out_hi`=raw and `out_lo`=~raw. Any pending turn-on is released at once.
- R6: If the raw level changes again while a deadtime is running, the timer restarts from the new edge. Both outputs stay 0 until S cycles after that edge, and then only the output for the new level turns on.
- R7: Reset is synchronous and active low. It sets the deadtime register to all ones (0xFFF) and drives both outputs to 0. The first sampling edge after reset starts a deadtime for the output selected by the raw level.
- R8: Each pair has its own timer. Activity on one pair does not change the outputs of another pair.
- R9: When `dt_wr_en` is 1 at a clock edge, the register loads `dt_wr_data`, and later deadtimes use the new value. When `dt_wr_en` is 0, `dt_wr_data` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_sel | input | 2 | Prescaler ratio select (0:÷1, 1:÷2, 2:÷4, 3:÷8) |
| dt_wr_en | input | 1 | Load strobe for the deadtime register |
| dt_wr_data | input | DT_W (12) | New deadtime value in prescaled ticks |
| pwm_raw | input | NPAIRS (3) | Raw pulse-width signal, one bit per pair |
| out_hi | output | NPAIRS (3) | High-side drive, one bit per pair |
| out_lo | output | NPAIRS (3) | Low-side drive, one bit per pair |

## Verification
The bench builds the block with two pairs and the full 12-bit deadtime. This keeps one pair free as a witness of independence, and it makes the all-ones reset value reachable at both ends of the prescaler range. It sweeps every prescaler setting against deadtime values 0 to 7, in both edge directions. That covers the zero-span pass-through and the minus-one rule at each ratio. It also runs the full 0xFFF span at divide-by-1 after reset and at divide-by-8, and runs a restart case.

// File: rtl/dtins_pkg.sv
// Package: shared types for the deadtime inserter.
// Assumes a two-bit prescaler select that names the power-of-two ratios 1..8.
package dtins_pkg;

    typedef enum logic [1:0] {
        PRE_DIV1 = 2'd0,
        PRE_DIV2 = 2'd1,
        PRE_DIV4 = 2'd2,
        PRE_DIV8 = 2'd3
    } presc_e;

    // Extra span bits needed for the largest ratio (x8).
    localparam int unsigned PRESC_SHIFT_W = 3;

endpackage

// File: rtl/dtins_dt_reg.sv
// Module: deadtime value register.
// Holds the deadtime count in prescaled ticks. Reset loads all ones.
// Assumes the write strobe and data are synchronous to clk.
module dtins_dt_reg #(
    parameter int unsigned DT_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DT_W-1:0] wr_data,
    output logic [DT_W-1:0] dt_q
);

    localparam logic [DT_W-1:0] DT_RESET = '1;

    // Load the value on a strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dt_q <= DT_RESET;
        end else if (wr_en) begin
            dt_q <= wr_data;
        end
    end

endmodule

// File: rtl/dtins_span.sv
// Module: turns a deadtime count into a span of bus cycles.
// Span = count at divide-by-one, ratio*count-1 at any other ratio, and 0 for a zero count.
// Purely combinational. Assumes SPAN_W >= DT_W + 3.
module dtins_span #(
    parameter int unsigned DT_W   = 12,
    parameter int unsigned SPAN_W = DT_W + dtins_pkg::PRESC_SHIFT_W
) (
    input  dtins_pkg::presc_e presc,
    input  logic [DT_W-1:0]   dt_val,
    output logic [SPAN_W-1:0] span
);

    localparam int unsigned PAD_W = SPAN_W - DT_W;

    logic [SPAN_W-1:0] scaled;
    logic              trim;

    // Scale the count by the power-of-two ratio.
    always_comb begin
        unique case (presc)
            dtins_pkg::PRE_DIV1: scaled = {{PAD_W{1'b0}}, dt_val};
            dtins_pkg::PRE_DIV2: scaled = {{PAD_W{1'b0}}, dt_val} << 1;
            dtins_pkg::PRE_DIV4: scaled = {{PAD_W{1'b0}}, dt_val} << 2;
            default:             scaled = {{PAD_W{1'b0}}, dt_val} << 3;
        endcase
    end

    // Take one cycle off for divided ratios with a nonzero count.
    always_comb begin
        trim = (presc != dtins_pkg::PRE_DIV1) && (dt_val != '0);
        span = trim ? scaled - SPAN_W'(1) : scaled;
    end

endmodule

// File: rtl/dtins_pair.sv
// Module: deadtime gate for one complementary pair.
// A raw level change turns off both drives at once and loads the timer with the span.
// The drive for the new level comes on when the timer runs out. A change during the
// wait reloads the timer. A zero span passes the level through and releases any wait.
// Assumes raw is synchronous to clk.
module dtins_pair #(
    parameter int unsigned SPAN_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw,
    input  logic [SPAN_W-1:0] span,
    output logic              hi,
    output logic              lo
);

    logic              lvl_q;
    logic              seen_q;
    logic [SPAN_W-1:0] wait_q;
    logic              edge_now;
    logic              zero_span;

    // Detect a new level, or the first sample after reset.
    always_comb begin
        edge_now  = !seen_q || (raw != lvl_q);
        zero_span = (span == '0);
    end

    // Track the level, run the wait timer and drive the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            seen_q <= 1'b0;
            wait_q <= '0;
            hi     <= 1'b0;
            lo     <= 1'b0;
        end else if (edge_now) begin
            lvl_q  <= raw;
            seen_q <= 1'b1;
            if (zero_span) begin
                wait_q <= '0;
                hi     <= raw;
                lo     <= !raw;
            end else begin
                wait_q <= span;
                hi     <= 1'b0;
                lo     <= 1'b0;
            end
        end else if (wait_q != '0) begin
            if (wait_q == SPAN_W'(1) || zero_span) begin
                wait_q <= '0;
                hi     <= lvl_q;
                lo     <= !lvl_q;
            end else begin
                wait_q <= wait_q - SPAN_W'(1);
            end
        end
    end

endmodule

// File: rtl/dtins_top.sv
// Module: complementary deadtime inserter for NPAIRS channel pairs.
// One shared deadtime register and prescaler select, and one timer per pair.
// Assumes all inputs are synchronous to clk. Reset is synchronous and active low.
module dtins_top #(
    parameter int unsigned NPAIRS = 3,
    parameter int unsigned DT_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        presc_sel,
    input  logic              dt_wr_en,
    input  logic [DT_W-1:0]   dt_wr_data,
    input  logic [NPAIRS-1:0] pwm_raw,
    output logic [NPAIRS-1:0] out_hi,
    output logic [NPAIRS-1:0] out_lo
);

    localparam int unsigned SPAN_W = DT_W + dtins_pkg::PRESC_SHIFT_W;

    logic [DT_W-1:0]   dt_q;
    logic [SPAN_W-1:0] span;
    dtins_pkg::presc_e presc;

    // Map the select pins onto the ratio type.
    always_comb presc = dtins_pkg::presc_e'(presc_sel);

    dtins_dt_reg #(.DT_W(DT_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dt_wr_en),
        .wr_data (dt_wr_data),
        .dt_q    (dt_q)
    );

    dtins_span #(.DT_W(DT_W), .SPAN_W(SPAN_W)) u_span (
        .presc  (presc),
        .dt_val (dt_q),
        .span   (span)
    );

    for (genvar g = 0; g < NPAIRS; g++) begin : g_pair
        dtins_pair #(.SPAN_W(SPAN_W)) u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (pwm_raw[g]),
            .span  (span),
            .hi    (out_hi[g]),
            .lo    (out_lo[g])
        );
    end

endmodule

// File: rtl/dtins_chk.sv
// Module: property checker for dtins_top, attached with bind.
// Watches the port levels, the deadtime register and the computed span.
module dtins_chk #(
    parameter int unsigned NPAIRS = 3,
    parameter int unsigned DT_W   = 12,
    parameter int unsigned SPAN_W = DT_W + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPAIRS-1:0] pwm_raw,
    input logic [NPAIRS-1:0] out_hi,
    input logic [NPAIRS-1:0] out_lo,
    input logic [DT_W-1:0]   dt_q,
    input logic [SPAN_W-1:0] span
);

    // R1: drives of a pair never overlap
    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hi & out_lo) == '0);

    // R2: high side only while the sampled raw level was high
    a_r2_hi_tracks_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hi & ~$past(pwm_raw)) == '0);

    // R3: low side only while the sampled raw level was low
    a_r3_lo_tracks_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (out_lo & $past(pwm_raw)) == '0);

    // R5: zero span passes the level through one cycle late
    a_r5_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(span) == '0) |->
            (out_hi == $past(pwm_raw) && out_lo == ~$past(pwm_raw)));

    // R7: register holds all ones straight after reset
    a_r7_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dt_q == '1 && out_hi == '0 && out_lo == '0));

endmodule

bind dtins_top dtins_chk #(
    .NPAIRS (NPAIRS),
    .DT_W   (DT_W),
    .SPAN_W (SPAN_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_raw (pwm_raw),
    .out_hi  (out_hi),
    .out_lo  (out_lo),
    .dt_q    (dt_q),
    .span    (span)
);

// File: tb/sim_dtins_top.sv
`timescale 1ns/1ps
module sim_dtins_top;

    localparam int NP = 2;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    presc_sel;
    logic          dt_wr_en;
    logic [DW-1:0] dt_wr_data;
    logic [NP-1:0] pwm_raw;
    logic [NP-1:0] out_hi;
    logic [NP-1:0] out_lo;

    int n_chk  = 0;
    int n_fail = 0;
    int cur_span = 0;

    always #2.5 clk = ~clk;

    dtins_top #(.NPAIRS(NP), .DT_W(DW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .presc_sel  (presc_sel),
        .dt_wr_en   (dt_wr_en),
        .dt_wr_data (dt_wr_data),
        .pwm_raw    (pwm_raw),
        .out_hi     (out_hi),
        .out_lo     (out_lo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int span_of(input int p, input int d);
        if (p == 0) return d;
        if (d == 0) return 0;
        return (d << p) - 1;
    endfunction

    task automatic set_cfg(input int p, input int d);
        @(negedge clk);
        presc_sel  = 2'(p);
        dt_wr_en   = 1'b1;
        dt_wr_data = DW'(d);
        @(negedge clk);
        dt_wr_en   = 1'b0;
        cur_span   = span_of(p, d);
    endtask

    // Flip pair 0 to dir, then count cycles until the incoming drive comes on.
    task automatic measure(input bit dir, input int exp, input string req);
        int  j = 0;
        int  overlap = 0;
        bit  off_first;
        bit  act;
        @(negedge clk);
        pwm_raw[0] = dir;
        @(negedge clk);
        off_first = dir ? !out_lo[0] : !out_hi[0];
        chk(off_first, dir ? "R2 low side off at once" : "R3 high side off at once",
            int'(off_first), 1);
        forever begin
            act = dir ? out_hi[0] : out_lo[0];
            if (out_hi[0] && out_lo[0]) overlap++;
            if (act || j > exp + 4) break;
            @(negedge clk);
            j++;
        end
        chk(j == exp, req, j, exp);
        chk(overlap == 0, "R1 no overlap", overlap, 0);
        chk(out_hi[1] && !out_lo[1], "R8 pair 1 undisturbed", int'(out_hi[1]), 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int j;
        rst_n      = 1'b0;
        presc_sel  = 2'd0;
        dt_wr_en   = 1'b0;
        dt_wr_data = '0;
        pwm_raw    = 2'b10;
        repeat (3) @(negedge clk);
        chk(out_hi == '0 && out_lo == '0, "R7 outputs low in reset", int'({out_hi, out_lo}), 0);

        // R7: reset value 0xFFF at divide-by-one gives 4095 cycles before turn-on
        rst_n = 1'b1;
        j = 0;
        @(negedge clk);
        while (!out_lo[0] && j < 5000) begin
            @(negedge clk);
            j++;
        end
        chk(j == 4095, "R7 reset deadtime 0xFFF", j, 4095);
        chk(out_hi[1] && !out_hi[0], "R7 R8 pair 1 high after same span", int'(out_hi[1]), 1);

        // R4 R2 R3 R5 R9: sweep ratios against small counts
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 8; d++) begin
                set_cfg(p, d);
                measure(1'b1, span_of(p, d), d == 0 ? "R5 R2 rise span" : "R4 R2 R9 rise span");
                measure(1'b0, span_of(p, d), d == 0 ? "R5 R3 fall span" : "R4 R3 R9 fall span");
            end
        end

        // R4: worked ratio-2 example, 5 -> 9 cycles
        set_cfg(1, 5);
        measure(1'b1, 9, "R4 ratio 2 value 5");
        measure(1'b0, 9, "R4 ratio 2 value 5");

        // R9: data without strobe leaves the value alone
        @(negedge clk);
        dt_wr_data = 12'd3;
        repeat (2) @(negedge clk);
        measure(1'b1, 9, "R9 no write without strobe");
        measure(1'b0, 9, "R9 no write without strobe");

        // R6: change back during the wait restarts the timer
        @(negedge clk);
        pwm_raw[0] = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(!out_hi[0] && !out_lo[0], "R6 both off mid wait", int'({out_hi[0], out_lo[0]}), 0);
        end
        pwm_raw[0] = 1'b0;
        j = 0;
        @(negedge clk);
        while (!out_lo[0] && j < 40) begin
            chk(!out_hi[0], "R6 high never on", int'(out_hi[0]), 0);
            @(negedge clk);
            j++;
        end
        chk(j == 9, "R6 restarted span", j, 9);

        // R4: full count at ratio 8 -> 32759 cycles
        set_cfg(3, 4095);
        measure(1'b1, 32759, "R4 ratio 8 full count");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule